// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time-of-Day Counter

This block keeps time of day for precision time stamping. It runs from a fixed 125 MHz clock. On every enabled clock it adds a nominal 8 ns to a 40-bit nanosecond count. Beneath that count sits a 32-bit fraction, in units of 2^-32 ns. A signed correction word adds to or subtracts from this fraction on every tick. The carry or borrow out of the fraction adds or removes one nanosecond, so software can pull the clock rate up or down in parts per billion.

Software reaches the block through a small word-wide register port. The port holds a control word, the correction word, a residue register and the low and high time words. Reading the residue register freezes the whole time in shadow registers, so the three reads that follow it form one coherent value. Software sets the time by writing the low word and then the high word.

Top module: `adj_time_counter`

## Requirements
- R1: Reset leaves these values at zero: the nanosecond count, the fraction, the correction word, the pending low word and the shadow words. Reset sets the disable flag, so a read of the control register (address 0) returns 0x80000000.
- R2: While control bit 31 is 1, the count and the fraction hold their values. Two snapshots taken any number of cycles apart are then equal.
- R3: After a write of 0 to bit 31 of the control register, the count advances on each clock. With a zero correction word each step is exactly 8 ns.
- R4: When bit 31 of the correction word (address 1) is 0, the fraction grows by bits 30:0 on every tick. That tick adds 9 ns if the fraction carries past 2^32 and 8 ns otherwise. The magnitude is ppb * 2^26 / 1953125, so the largest offset of 62,499,999 ppb gives 0x7FFFFFDD.
- R5: When bit 31 of the correction word is 1, the fraction shrinks by bits 30:0 on every tick, modulo 2^32. That tick adds 7 ns if the subtraction borrows and 8 ns otherwise.
- R6: A read of the residue register (address 2) returns the fraction. In the same cycle it copies the count into the shadow registers. Reads of the low word (address 3) and the high word (address 4) return those shadow values until the next residue read.
- R7: A high-word read returns count bits 39:32 in data bits 7:0. Data bits 31:8 read as zero.
- R8: A write to address 3 holds the new low word as pending. A later write to address 4 loads {wdata[7:0], pending low} into the count and clears the fraction at the same edge.
- R9: The count wraps from 2^40-1 to 0 without a pause. It then continues in 8 ns steps.
- R10: Read data is registered. It appears on rdata at the clock edge that samples rd_en, and it stays there until the next read. A read of the correction word returns the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz timing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 control, 1 correction, 2 residue, 3 low, 4 high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Each result falls due at a fixed cycle after its stimulus.
- A read's data appears after the edge that samples rd_en.
- A write, including the high-word time load, takes effect at its sampling edge.
- A residue read captures the count as it stood just before that edge's own tick.

The bench drives inputs on falling edges and compares rdata on every falling edge with a behavioural model that steps at the same edges. The directed snapshot checks work out each expected time by counting the exact ticks between the load edge and the residue-read edge. Those expected times include the carry and borrow cases and the 2^40 wrap.

// File: rtl/adj_time_counter.sv
module adj_time_counter #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int STEP_NS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int HI_W  = NS_W - DW;
  localparam int MAG_W = DW - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_RATE = AW'(1);
  localparam logic [AW-1:0] A_FRAC = AW'(2);
  localparam logic [AW-1:0] A_LO   = AW'(3);
  localparam logic [AW-1:0] A_HI   = AW'(4);

  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic              dis_q;
  logic [DW-1:0]     rate_q;
  logic [DW-1:0]     lo_pend;
  logic [DW-1:0]     sh_lo;
  logic [HI_W-1:0]   sh_hi;
  logic [DW-1:0]     rd_q;

  wire              sub_dir = rate_q[DW-1];
  wire [FRAC_W:0]   mag_ext = (FRAC_W+1)'(rate_q[MAG_W-1:0]);
  wire [FRAC_W:0]   f_sum   = {1'b0, frac_q} + mag_ext;
  wire [FRAC_W:0]   f_dif   = {1'b0, frac_q} - mag_ext;
  wire [NS_W-1:0]   ns_inc  = sub_dir ? NS_W'(STEP_NS) - NS_W'(f_dif[FRAC_W])
                                      : NS_W'(STEP_NS) + NS_W'(f_sum[FRAC_W]);
  wire [FRAC_W-1:0] frac_nx = sub_dir ? f_dif[FRAC_W-1:0] : f_sum[FRAC_W-1:0];
  wire              ld_time = wr_en && addr == A_HI;
  wire              snap    = rd_en && addr == A_FRAC;

  assign rdata = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (ld_time) begin
      ns_q   <= {wdata[HI_W-1:0], lo_pend};
      frac_q <= '0;
    end else if (!dis_q) begin
      ns_q   <= ns_q + ns_inc;
      frac_q <= frac_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= 1'b1;
      rate_q  <= '0;
      lo_pend <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  dis_q   <= wdata[DW-1];
        A_RATE:  rate_q  <= wdata;
        A_LO:    lo_pend <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_lo <= '0;
      sh_hi <= '0;
    end else if (snap) begin
      sh_lo <= ns_q[DW-1:0];
      sh_hi <= ns_q[NS_W-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTRL:  rd_q <= {dis_q, {(DW-1){1'b0}}};
        A_RATE:  rd_q <= rate_q;
        A_FRAC:  rd_q <= DW'(frac_q);
        A_LO:    rd_q <= sh_lo;
        A_HI:    rd_q <= {{(DW-HI_W){1'b0}}, sh_hi};
        default: rd_q <= '0;
      endcase
    end
  end
endmodule

module adj_time_counter_chk #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int STEP_NS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [NS_W-1:0]   ns_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic              dis_q,
  input logic [DW-1:0]     rate_q,
  input logic [DW-1:0]     lo_pend,
  input logic [DW-1:0]     sh_lo,
  input logic [NS_W-DW-1:0] sh_hi
);
  localparam int HI_W = NS_W - DW;
  wire no_load = !(wr_en && addr == AW'(4));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_q && no_load) |=> ($stable(ns_q) && $stable(frac_q)));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis_q && no_load && !rate_q[DW-1]) |=>
      (NS_W'(ns_q - $past(ns_q)) == NS_W'(STEP_NS) || NS_W'(ns_q - $past(ns_q)) == NS_W'(STEP_NS + 1)));

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis_q && no_load && rate_q[DW-1]) |=>
      (NS_W'(ns_q - $past(ns_q)) == NS_W'(STEP_NS) || NS_W'(ns_q - $past(ns_q)) == NS_W'(STEP_NS - 1)));

  // R8
  time_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(4)) |=>
      (frac_q == '0 && ns_q == {$past(wdata[HI_W-1:0]), $past(lo_pend)}));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == AW'(2)) |=> ($stable(sh_lo) && $stable(sh_hi)));

  // R7
  hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(4)) |=> (rdata[DW-1:HI_W] == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind adj_time_counter adj_time_counter_chk #(
  .NS_W(NS_W), .FRAC_W(FRAC_W), .DW(DW), .AW(AW), .STEP_NS(STEP_NS)
) u_chk (.*);

// File: tb/adj_time_counter_bench.sv
module adj_time_counter_bench;
  localparam time CLK_PERIOD = 8ns;
  localparam longint MASK40 = 64'h00FF_FFFF_FFFF;
  localparam longint TWO32  = 64'h1_0000_0000;

  logic        clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  adj_time_counter u_adj_time_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  longint m_ns, m_frac, ns_n, fr_n, mag, inc;
  logic [31:0] m_rate, m_plo, m_shlo, m_rd, sl_n, rd_n;
  logic [7:0]  m_shhi, sh_n;
  logic        m_dis;

  always @(posedge clk) begin
    if (rst) begin
      m_ns = 0; m_frac = 0; m_rate = 0; m_plo = 0; m_shlo = 0; m_shhi = 0;
      m_rd = 0; m_dis = 1;
    end else begin
      ns_n = m_ns; fr_n = m_frac; rd_n = m_rd; sl_n = m_shlo; sh_n = m_shhi;
      if (rd_en) begin
        case (addr)
          3'd0: rd_n = {m_dis, 31'b0};
          3'd1: rd_n = m_rate;
          3'd2: begin rd_n = m_frac[31:0]; sl_n = m_ns[31:0]; sh_n = m_ns[39:32]; end
          3'd3: rd_n = m_shlo;
          3'd4: rd_n = {24'b0, m_shhi};
          default: rd_n = 0;
        endcase
      end
      if (!m_dis) begin
        mag = longint'(m_rate[30:0]);
        if (m_rate[31]) begin
          if (m_frac >= mag) begin fr_n = m_frac - mag; inc = 8; end
          else begin fr_n = m_frac + TWO32 - mag; inc = 7; end
        end else begin
          fr_n = m_frac + mag; inc = 8;
          if (fr_n >= TWO32) begin fr_n = fr_n - TWO32; inc = 9; end
        end
        ns_n = (m_ns + inc) & MASK40;
      end
      if (wr_en) begin
        case (addr)
          3'd0: m_dis = wdata[31];
          3'd1: m_rate = wdata;
          3'd3: m_plo = wdata;
          3'd4: begin ns_n = {24'b0, wdata[7:0], m_plo}; fr_n = 0; end
          default: ;
        endcase
      end
      m_ns = ns_n; m_frac = fr_n; m_rd = rd_n; m_shlo = sl_n; m_shhi = sh_n;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) check({cur_req, " model"}, rdata, m_rd);

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; v = rdata;
  endtask

  task automatic snap(output logic [31:0] f, output logic [31:0] lo, output logic [31:0] hi);
    rd(3'd2, f); rd(3'd3, lo); rd(3'd4, hi);
  endtask

  task automatic expect_snap(input string req, input logic [31:0] f,
                             input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] af, al, ah;
    snap(af, al, ah);
    check({req, " frac"}, af, f);
    check({req, " low"}, al, lo);
    check({req, " high"}, ah, hi);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, f1, l1, h1, f2, l2, h2;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R1";
    rd(3'd0, v); check("R1 ctrl", v, 32'h8000_0000);
    expect_snap("R1", 0, 0, 0);
    rd(3'd1, v); check("R1 rate", v, 0);

    cur_req = "R2";
    repeat (5) @(negedge clk);
    expect_snap("R2 idle", 0, 0, 0);

    cur_req = "R3";
    wr(3'd0, 0);
    expect_snap("R3 start", 0, 0, 0);
    repeat (5) @(negedge clk);
    expect_snap("R3 run", 0, 64, 0);

    cur_req = "R8";
    wr(3'd3, 32'hFFFF_FFF0); wr(3'd4, 32'h12);
    expect_snap("R8 load", 0, 32'hFFFF_FFF0, 32'h12);
    expect_snap("R8 carry", 0, 8, 32'h13);

    cur_req = "R6";
    repeat (10) @(negedge clk);
    rd(3'd3, v); check("R6 low hold", v, 8);
    rd(3'd4, v); check("R6 high hold", v, 32'h13);

    cur_req = "R9";
    wr(3'd3, 32'hFFFF_FFF8); wr(3'd4, 32'hFFFF_FFFF);
    expect_snap("R7 high bits", 0, 32'hFFFF_FFF8, 32'h0000_00FF);
    expect_snap("R9 wrap", 0, 16, 0);

    cur_req = "R4";
    wr(3'd1, 32'h4000_0000); wr(3'd3, 0); wr(3'd4, 0);
    expect_snap("R4 load", 0, 0, 0);
    expect_snap("R4 three", 32'hC000_0000, 24, 0);
    expect_snap("R4 carry", 32'h8000_0000, 49, 0);
    wr(3'd1, 32'h7FFF_FFDD); wr(3'd3, 0); wr(3'd4, 0);
    expect_snap("R4 max load", 0, 0, 0);
    expect_snap("R4 max", 32'h7FFF_FF97, 25, 0);

    cur_req = "R5";
    wr(3'd1, 32'hC000_0000); wr(3'd3, 100); wr(3'd4, 0);
    expect_snap("R5 load", 0, 100, 0);
    expect_snap("R5 borrow", 32'h4000_0000, 123, 0);

    cur_req = "R10";
    rd(3'd1, v); check("R10 rate readback", v, 32'hC000_0000);
    repeat (3) @(negedge clk);
    check("R10 rdata held", rdata, 32'hC000_0000);

    cur_req = "R2";
    wr(3'd0, 32'h8000_0000);
    snap(f1, l1, h1);
    repeat (10) @(negedge clk);
    snap(f2, l2, h2);
    check("R2 frac frozen", f2, f1);
    check("R2 low frozen", l2, l1);
    check("R2 high frozen", h2, h1);
    rd(3'd0, v); check("R2 ctrl", v, 32'h8000_0000);

    finish_run();
  end
endmodule